// File: doc/BRIEF.md
# Prescaled Wake-Up Counter

This block is a free-running wake-up counter. A base clock passes through a prescaler whose divisor is a power of two, chosen by a 4-bit select field. Each prescaled tick advances a wide count by one. A second count beside it runs from 0 to 59 and then back to 0. Four event sources (prescaler tick, count changed, wide-count wrap and modulo-60 wrap) each set a sticky status flag. Each flag has its own enable. The enabled flags are ORed and registered onto a single interrupt line.

Software reaches the block through a small synchronous register port, with a write strobe, a 3-bit word address and a combinational read mux. Address 0 is the control word. Address 1 is the status word, and a one written to a status bit clears that flag. Address 2 reads the wide count, zero-extended to 32 bits. Address 3 reads the modulo-60 count. The width of the wide count is a parameter, 32 by default. A test configuration can narrow it so that a wrap can be reached in a short run.

Top module: `wkt_timer`

## Requirements
- R1: After reset the control word reads 0, the status word reads 0x0000C000, both counts read 0 and `irq` is 0.
- R2: Control bits [11:8] hold a select N from 0 to 15, and control bit 7 is the run bit. While the run bit is 1, the wide count at address 2 goes up by exactly one every 2^N clock cycles.
- R3: A control write that changes N restarts the prescaler phase from zero. The count then first changes 2^N cycles after the write edge.
- R4: While the run bit is 0, the prescaler and both counts hold their values and no flag is set.
- R5: Status bit 1 (tick flag) is set by every prescaled tick.
- R6: Status bit 0 (count-changed flag) is set in the cycle after any change of the wide count value.
- R7: Status bit 3 (wrap flag) is set when the wide count goes from all ones to zero.
- R8: The count at address 3 advances with each tick, stays in 0..59 and wraps from 59 to 0. That wrap sets status bit 4.
- R9: Writing a 1 to a status flag bit clears that flag, and writing 0 leaves it unchanged. Status bits 15:14 always read 1, and every other status bit reads 0.
- R10: When a flag's event and a software clear of that flag fall in the same cycle, the flag stays set.
- R11: Control bits 0, 1, 3 and 4 enable the flags in the same bit positions. Control bit 2 and every bit not named here read 0. `irq` is high in the cycle after any enabled flag is set, and low in the cycle after none is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Word address: 0 control, 1 status, 2 count, 3 modulo-60 count |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Registered OR of the enabled status flags |

## Verification
The hardest situation to create from the ports is a software clear that lands in the same cycle as the event it clears. With the select at 0 a tick fires on every cycle. The count also changes on every cycle, so a status clear written while the counter runs always collides with both the tick event and the count-changed event, and both flags must survive. The wide-count wrap is reached by building the bench with a narrow count. Running segments of chosen length then carry the count across all ones and the modulo count across 59 at varied offsets. The expected flags and counts for each segment are computed from the number of ticks taken.

// File: rtl/wkt_pkg.sv
package wkt_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;
    localparam int PSEL_W = 4;
    localparam int EVT_N  = 4;

    // bit positions shared by the control enables and the status flags
    localparam int B_CHG  = 0;
    localparam int B_TICK = 1;
    localparam int B_WRAP = 3;
    localparam int B_M60  = 4;
    localparam int B_RUN  = 7;
    localparam int B_PSL  = 8;

    localparam logic [DATA_W-1:0] STAT_SYNC = 32'h0000_C000;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_STAT = 3'd1,
        A_CNT  = 3'd2,
        A_MOD  = 3'd3
    } reg_addr_e;

    typedef struct packed {
        logic m60;
        logic wrap;
        logic tick;
        logic chg;
    } evt_t;

    typedef struct packed {
        logic              run;
        logic [PSEL_W-1:0] psel;
        evt_t              ien;
    } ctrl_t;

    function automatic evt_t evt_from_word(input logic [DATA_W-1:0] w);
        evt_t e;
        e.chg  = w[B_CHG];
        e.tick = w[B_TICK];
        e.wrap = w[B_WRAP];
        e.m60  = w[B_M60];
        return e;
    endfunction

    function automatic logic [DATA_W-1:0] evt_to_word(input evt_t e);
        logic [DATA_W-1:0] w;
        w         = '0;
        w[B_CHG]  = e.chg;
        w[B_TICK] = e.tick;
        w[B_WRAP] = e.wrap;
        w[B_M60]  = e.m60;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w                     = evt_to_word(c.ien);
        w[B_RUN]              = c.run;
        w[B_PSL +: PSEL_W]    = c.psel;
        return w;
    endfunction

endpackage

// File: rtl/wkt_prescaler.sv
module wkt_prescaler
    import wkt_pkg::*;
#(
    parameter int SEL_W = PSEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] psel,
    input  logic             phase_clr,
    output logic             tick
);
    localparam int PH_W = (1 << SEL_W) - 1;

    logic [PH_W-1:0] ph_q;
    logic [PH_W:0]   span;
    logic [PH_W-1:0] lim;

    // divisor 2^psel, terminal phase value is divisor minus one
    assign span = (PH_W+1)'(1) << psel;
    assign lim  = PH_W'(span - (PH_W+1)'(1));
    assign tick = run && (ph_q == lim);

    always_ff @(posedge clk) begin
        if (rst || phase_clr) begin
            ph_q <= '0;
        end else if (run) begin
            if (tick) ph_q <= '0;
            else      ph_q <= ph_q + PH_W'(1);
        end
    end

    AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (rst)
        phase_clr |=> (ph_q == '0)); // R3
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run && !phase_clr) |=> $stable(ph_q)); // R4
    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (rst)
        ph_q <= lim); // R2

endmodule

// File: rtl/wkt_counter.sv
module wkt_counter
    import wkt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int MOD_N = 60
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tick,
    output logic [CNT_W-1:0]         cnt,
    output logic [$clog2(MOD_N)-1:0] mcnt,
    output evt_t                     evt
);
    localparam int MW = $clog2(MOD_N);
    localparam logic [MW-1:0] M_TOP = MW'(MOD_N - 1);

    logic [CNT_W-1:0] cnt_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            cnt_prev <= '0;
            mcnt     <= '0;
        end else begin
            cnt_prev <= cnt;
            if (tick) begin
                cnt  <= cnt + CNT_W'(1);
                mcnt <= (mcnt == M_TOP) ? '0 : mcnt + MW'(1);
            end
        end
    end

    always_comb begin
        evt.tick = tick;
        evt.chg  = (cnt != cnt_prev);
        evt.wrap = tick && (&cnt);
        evt.m60  = tick && (mcnt == M_TOP);
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == $past(cnt) + CNT_W'(1))); // R2
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(cnt) && $stable(mcnt))); // R4
    AST_MOD_RANGE: assert property (@(posedge clk) disable iff (rst)
        mcnt <= M_TOP); // R8
    AST_CHANGE_SEEN: assert property (@(posedge clk) disable iff (rst)
        tick |=> evt.chg); // R6

endmodule

// File: rtl/wkt_flags.sv
module wkt_flags
    import wkt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  evt_t evt,
    input  evt_t clr,
    input  evt_t ien,
    output evt_t flg,
    output logic irq
);
    logic [EVT_N-1:0] ev_v;
    logic [EVT_N-1:0] cl_v;
    logic [EVT_N-1:0] en_v;
    logic [EVT_N-1:0] fl_v;

    assign ev_v = evt;
    assign cl_v = clr;
    assign en_v = ien;
    assign flg  = fl_v;

    for (genvar i = 0; i < EVT_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) fl_v[i] <= 1'b0;
            else     fl_v[i] <= (fl_v[i] && !cl_v[i]) || ev_v[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(fl_v & en_v);
    end

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        (|ev_v) |=> ((fl_v & $past(ev_v)) == $past(ev_v))); // R10
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (|(fl_v & ~cl_v)) |=> ((fl_v & $past(fl_v & ~cl_v)) == $past(fl_v & ~cl_v))); // R9
    AST_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (|(cl_v & ~ev_v)) |=> ((fl_v & $past(cl_v & ~ev_v)) == '0)); // R9
    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
        (|(fl_v & en_v)) |=> irq); // R11
    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (rst)
        !(|(fl_v & en_v)) |=> !irq); // R11

endmodule

// File: rtl/wkt_regs.sv
module wkt_regs
    import wkt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int MW    = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  evt_t              flg,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [MW-1:0]     mcnt,
    output ctrl_t             ctrl,
    output evt_t              clr,
    output logic              phase_clr,
    output logic [DATA_W-1:0] rdata
);
    logic               wr_ctrl;
    logic               wr_stat;
    logic [PSEL_W-1:0]  new_psel;

    assign wr_ctrl  = wr && (addr == A_CTRL);
    assign wr_stat  = wr && (addr == A_STAT);
    assign new_psel = wdata[B_PSL +: PSEL_W];

    assign phase_clr = wr_ctrl && (new_psel != ctrl.psel);
    assign clr       = wr_stat ? evt_from_word(wdata) : evt_t'('0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl.run  <= wdata[B_RUN];
            ctrl.psel <= new_psel;
            ctrl.ien  <= evt_from_word(wdata);
        end
    end

    always_comb begin
        unique case (addr)
            A_CTRL:  rdata = ctrl_to_word(ctrl);
            A_STAT:  rdata = STAT_SYNC | evt_to_word(flg);
            A_CNT:   rdata = DATA_W'(cnt);
            A_MOD:   rdata = DATA_W'(mcnt);
            default: rdata = '0;
        endcase
    end

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> (ctrl.run == $past(wdata[B_RUN]) && ctrl.psel == $past(new_psel))); // R2
    AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> $stable(ctrl)); // R11

endmodule

// File: rtl/wkt_timer.sv
module wkt_timer
    import wkt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int MOD_N = 60
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    localparam int MW = $clog2(MOD_N);

    ctrl_t            ctrl;
    evt_t             clr;
    evt_t             evt;
    evt_t             flg;
    logic             phase_clr;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic [MW-1:0]    mcnt;

    wkt_regs #(.CNT_W(CNT_W), .MW(MW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .flg       (flg),
        .cnt       (cnt),
        .mcnt      (mcnt),
        .ctrl      (ctrl),
        .clr       (clr),
        .phase_clr (phase_clr),
        .rdata     (reg_rdata)
    );

    wkt_prescaler #(.SEL_W(PSEL_W)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .run       (ctrl.run),
        .psel      (ctrl.psel),
        .phase_clr (phase_clr),
        .tick      (tick)
    );

    wkt_counter #(.CNT_W(CNT_W), .MOD_N(MOD_N)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .cnt  (cnt),
        .mcnt (mcnt),
        .evt  (evt)
    );

    wkt_flags u_flg (
        .clk (clk),
        .rst (rst),
        .evt (evt),
        .clr (clr),
        .ien (ctrl.ien),
        .flg (flg),
        .irq (irq)
    );

endmodule

// File: tb/wkt_timer_bench.sv
module wkt_timer_bench;

    localparam int CW = 8;
    localparam int CMASK = (1 << CW) - 1;
    localparam logic [31:0] RUN = 32'h80;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    wkt_timer #(.CNT_W(CW), .MOD_N(60)) u_wkt_timer (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 180000) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog act=%0d exp<%0d", cyc, 180000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_change(input logic [31:0] base, output int dt);
        logic [31:0] v;
        dt = 0;
        reg_addr = 3'd2;
        do begin
            @(negedge clk);
            dt++;
            #1;
            v = reg_rdata;
        end while (v == base && dt < 40000);
    endtask

    initial begin
        logic [31:0] v, base, c0, c1, m0, m1, st, msk, expst;
        int d1, d2, tk;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, v); check("R1 ctrl", v, 32'h0);
        rd(3'd1, v); check("R1 status", v, 32'hC000);
        rd(3'd2, v); check("R1 count", v, 32'h0);
        rd(3'd3, v); check("R1 mod60", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R11 readback: reserved bit 2 and unnamed bits read 0
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, v); check("R11 ctrl readback", v, 32'h0F9B);
        wr(3'd0, 32'h0);

        // R2 period sweep, R3 phase restart on select change
        for (int n = 0; n <= 10; n++) begin
            wr(3'd0, 32'h0);
            wr(3'd0, RUN | (32'(n) << 8));
            rd(3'd2, base);
            wait_change(base, d1);
            check("R3 first tick after select", 32'(d1), 32'(1 << n));
            rd(3'd2, v); check("R2 step of one", v, (base + 1) & CMASK);
            base = v;
            wait_change(base, d2);
            check("R2 period", 32'(d2), 32'(1 << n));
        end
        wr(3'd0, 32'h0);
        wr(3'd0, RUN | (32'd15 << 8));
        rd(3'd2, base);
        wait_change(base, d1);
        check("R2 R3 divide by 32768", 32'(d1), 32'd32768);

        // R3 restart in mid phase
        wr(3'd0, RUN | (32'd4 << 8));
        repeat (7) @(negedge clk);
        wr(3'd0, RUN | (32'd5 << 8));
        rd(3'd2, base);
        wait_change(base, d1);
        check("R3 mid-phase restart", 32'(d1), 32'd32);

        // R4 hold while stopped
        wr(3'd0, 32'h0);
        repeat (3) @(negedge clk);
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd2, c0); rd(3'd3, m0);
        repeat (40) @(negedge clk);
        rd(3'd2, c1); check("R4 count holds", c1, c0);
        rd(3'd3, m1); check("R4 mod60 holds", m1, m0);
        rd(3'd1, st); check("R4 no flags while stopped", st, 32'hC000);

        // R5..R9, R11 run segments with select 0
        for (int i = 0; i < 8; i++) begin
            int len;
            len = 20 + 29 * i;
            msk = ((i & 1) ? 32'h1 : 32'h0) | ((i & 2) ? 32'h8 : 32'h0) |
                  ((i & 4) ? 32'h10 : 32'h0) | ((i == 5) ? 32'h2 : 32'h0);
            wr(3'd0, msk);
            repeat (2) @(negedge clk);
            wr(3'd1, 32'hFFFF_FFFF);
            rd(3'd1, st); check("R9 clear all", st, 32'hC000);
            rd(3'd2, c0); rd(3'd3, m0);
            wr(3'd0, RUN | msk);
            repeat (len) @(negedge clk);
            wr(3'd0, msk);
            repeat (3) @(negedge clk);
            rd(3'd2, c1); rd(3'd3, m1);
            tk = int'((c1 - c0) & CMASK);
            check("R2 ticks in segment", 32'(tk), 32'(len + 2));
            check("R8 mod60 value", m1, (m0 + 32'(len + 2)) % 60);
            expst = 32'hC000 | 32'h3;
            if (c0 + 32'(len + 2) > CMASK) expst |= 32'h8;
            if (m0 + 32'(len + 2) >= 60) expst |= 32'h10;
            rd(3'd1, st); check("R5 R6 R7 R8 flags", st, expst);
            check("R11 irq mask", {31'b0, irq}, {31'b0, |(expst & msk)});
            wr(3'd1, 32'h0);
            rd(3'd1, v); check("R9 write zero no effect", v, expst);
            wr(3'd1, 32'hFFFF_3FE4);
            rd(3'd1, v); check("R9 sync bits survive write", v, expst);
        end

        // R10 clear collides with tick and change events
        wr(3'd0, RUN);
        repeat (4) @(negedge clk);
        wr(3'd1, 32'h3);
        rd(3'd1, v); check("R10 event beats clear", v & 32'h3, 32'h3);

        // R9 clear between ticks takes effect
        wr(3'd0, RUN | (32'd6 << 8));
        rd(3'd2, base);
        wait_change(base, d1);
        repeat (3) @(negedge clk);
        wr(3'd1, 32'h3);
        rd(3'd1, v); check("R9 clear between ticks", v & 32'h3, 32'h0);

        // R11 irq one cycle after the enabled flag
        wr(3'd0, 32'h2);
        repeat (3) @(negedge clk);
        wr(3'd1, 32'hFFFF_FFFF);
        check("R11 irq low before run", {31'b0, irq}, 32'h0);
        wr(3'd0, RUN | 32'h2 | (32'd3 << 8));
        d1 = 0;
        do begin
            @(negedge clk);
            d1++;
            rd(3'd1, v);
        end while (v[1] == 1'b0 && d1 < 100);
        check("R5 tick flag seen", {31'b0, v[1]}, 32'h1);
        check("R11 irq still low", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R11 irq high one cycle later", {31'b0, irq}, 32'h1);
        wr(3'd0, 32'h0);
        @(negedge clk);
        check("R11 irq low after disable", {31'b0, irq}, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule